// File: doc/BRIEF.md
# Width-Converting Stream FIFO with Programmable Watermarks

This block is a single-clock buffer between a producer that delivers `IN_W`-bit words and a consumer that takes `OUT_W`-bit words. One width must be an integer multiple of the other. Storage is a circular array of granules, each `min(IN_W, OUT_W)` bits wide. Occupancy is kept exactly, so the stored bit count is always known. When words are wide and reads are narrow, each stored word leaves as several slices, lowest slice first. When writes are narrow and reads are wide, successive writes are packed from the low end of the output word upward.

Both data sides use valid/ready. On the write side, `in_ready` is the inverse of the registered full flag. A transfer offered while `in_ready` is low is discarded, and the producer is expected to hold it until `in_ready` returns. On the read side, `out_valid` is the inverse of the registered empty flag, and `out_data` is presented combinationally from the head of the buffer. A pull with `out_ready` high while `out_valid` is low moves nothing.

Each refused attempt is reported as a single-cycle `overflow` or `underflow` pulse in the cycle after the attempt. Two watermark inputs set where the almost-empty and almost-full flags switch. They are runtime values, and the flags use the value present at the clock edge that produced them. A correct configuration satisfies `IN_W*DEPTH/G >= IN_W/G + OUT_W/G - 1`, with `G = min(IN_W, OUT_W)`.

Top module: `widthconv_fifo`

## Requirements
- R1: While reset is low and in the cycle after it is released: `empty`=1, `almost_empty`=1, `almost_full`=0, `full`=0, `out_valid`=0, `overflow`=0 and `underflow`=0.
- R2: After each clock edge, `empty` is 1 exactly when the stored bit count is less than `OUT_W`, and `out_valid` is its inverse.
- R3: After each clock edge, `full` is 1 exactly when the stored bit count plus `IN_W` exceeds `IN_W*DEPTH`, and `in_ready` is its inverse.
- R4: After each clock edge, `almost_empty` is 1 exactly when the stored bit count is at most `OUT_W` times the `ae_level` value sampled at that edge.
- R5: After each clock edge, `almost_full` is 1 exactly when the stored bit count is at least `IN_W` times (`DEPTH` minus the `af_level` value sampled at that edge). An `af_level` of `DEPTH` or more makes the flag 1.
- R6: A write offered while `full` is 1 changes neither the stored data nor the count, and `overflow` is 1 for the following cycle only.
- R7: A read requested while `empty` is 1 removes nothing, and `underflow` is 1 for the following cycle only.
- R8: Data leaves bit-exact and in write order. For wide writes, bits [OUT_W-1:0] of a word leave first. For narrow writes, earlier writes occupy the lower bits of a read word.
- R9: A write and a read both accepted at the same edge are both completed in that cycle. The count changes by `IN_W-OUT_W` and no stall results.
- R10: `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Space for one more write word |
| in_data | input | IN_W | Write word |
| out_valid | output | 1 | At least one read word is stored |
| out_ready | input | 1 | Consumer takes `out_data` |
| out_data | output | OUT_W | Head read word |
| ae_level | input | THR_W | Almost-empty level, in read words |
| af_level | input | THR_W | Almost-full margin, in write words |
| empty | output | 1 | Fewer than OUT_W bits stored |
| full | output | 1 | Another write word would not fit |
| almost_empty | output | 1 | Low watermark reached |
| almost_full | output | 1 | High watermark reached |
| overflow | output | 1 | Pulse: previous-cycle write refused |
| underflow | output | 1 | Pulse: previous-cycle read refused |

## Verification
Two events can land in the same cycle: a narrow read completing and a wide write being accepted. This is most telling at the full boundary, where a pull frees only part of a write slot and the write must still be refused. The bench holds both `in_valid` and `out_ready` high for long runs. It also drives random valid/ready patterns while moving both levels, including margins at or beyond the depth. A bit-count model applies the registered-flag timing, and a byte scoreboard judges every returned slice.

// File: rtl/widthconv_pkg.sv
package widthconv_pkg;

  typedef struct packed {
    logic empty;
    logic full;
    logic aempty;
    logic afull;
  } wcf_flags_t;

  function automatic int wcf_min(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/wcf_store.sv
module wcf_store #(
  parameter int GW   = 8,
  parameter int WR_G = 4,
  parameter int RD_G = 1,
  parameter int NGR  = 32,
  parameter int PW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_acc,
  input  logic [WR_G*GW-1:0] wr_data,
  input  logic               rd_acc,
  output logic [RD_G*GW-1:0] rd_data,
  output logic [PW-1:0]      wr_ptr_o,
  output logic [PW-1:0]      rd_ptr_o
);

  logic [GW-1:0] mem_q [NGR];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [PW-1:0] rd_idx [RD_G];

  // Circular granule index: base plus offset, folded once into range.
  function automatic logic [PW-1:0] wrap(input logic [PW-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= NGR) s = s - NGR;
    return PW'(s);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_acc) wr_ptr_q <= wrap(wr_ptr_q, WR_G);
      if (rd_acc) rd_ptr_q <= wrap(rd_ptr_q, RD_G);
    end
  end

  // Granule k of a write word lands k slots after the write pointer.
  always_ff @(posedge clk) begin
    if (wr_acc) begin
      for (int k = 0; k < WR_G; k++) begin
        mem_q[wrap(wr_ptr_q, k)] <= wr_data[k*GW +: GW];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < RD_G; k++) begin
      rd_idx[k] = wrap(rd_ptr_q, k);
    end
  end

  for (genvar g = 0; g < RD_G; g++) begin : g_rd
    assign rd_data[g*GW +: GW] = mem_q[rd_idx[g]];
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;

endmodule

// File: rtl/wcf_level.sv
module wcf_level
  import widthconv_pkg::*;
#(
  parameter int WR_G  = 4,
  parameter int RD_G  = 1,
  parameter int NGR   = 32,
  parameter int DEPTH = 8,
  parameter int THR_W = 4,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc,
  input  logic             rd_acc,
  input  logic [THR_W-1:0] ae_level,
  input  logic [THR_W-1:0] af_level,
  output logic [CW-1:0]    fill_o,
  output wcf_flags_t       flags_o
);

  localparam int XW = CW + THR_W + 8;

  logic [CW-1:0] fill_q, fill_nx;
  logic [XW-1:0] fill_x, ae_lim, af_lim;
  wcf_flags_t    flags_nx, flags_q;

  always_comb begin
    fill_nx = fill_q;
    if (wr_acc) fill_nx = fill_nx + CW'(WR_G);
    if (rd_acc) fill_nx = fill_nx - CW'(RD_G);
  end

  // Limits are in granules, so the comparisons are exact in bits.
  always_comb begin
    fill_x = XW'(fill_nx);
    ae_lim = XW'(RD_G) * XW'(ae_level);
    if (XW'(af_level) >= XW'(DEPTH)) af_lim = '0;
    else af_lim = XW'(WR_G) * (XW'(DEPTH) - XW'(af_level));
    flags_nx.empty  = fill_nx < CW'(RD_G);
    flags_nx.full   = (fill_x + XW'(WR_G)) > XW'(NGR);
    flags_nx.aempty = fill_x <= ae_lim;
    flags_nx.afull  = fill_x >= af_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      flags_q <= '{empty: 1'b1, full: 1'b0, aempty: 1'b1, afull: 1'b0};
    end else begin
      fill_q  <= fill_nx;
      flags_q <= flags_nx;
    end
  end

  assign fill_o  = fill_q;
  assign flags_o = flags_q;

  // R10
  no_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q.full && flags_q.empty));

  // R2
  empty_tracks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.empty == (fill_q < CW'(RD_G)));

  // R3
  full_tracks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.full == ((XW'(fill_q) + XW'(WR_G)) > XW'(NGR)));

  // R6
  held_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.full && !rd_acc) |=> (fill_q == $past(fill_q)));

  // R7
  held_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.empty && !wr_acc) |=> (fill_q == $past(fill_q)));

endmodule

// File: rtl/wcf_events.sv
module wcf_events (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic full,
  input  logic empty,
  output logic ovf_o,
  output logic unf_o
);

  logic ovf_q, unf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= in_valid && full;
      unf_q <= out_ready && empty;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  // R7
  unf_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty) |=> !unf_q);

endmodule

// File: rtl/widthconv_fifo.sv
module widthconv_fifo
  import widthconv_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 8,
  parameter int DEPTH = 8,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  input  logic [THR_W-1:0] ae_level,
  input  logic [THR_W-1:0] af_level,
  output logic             empty,
  output logic             full,
  output logic             almost_empty,
  output logic             almost_full,
  output logic             overflow,
  output logic             underflow
);

  localparam int GW   = wcf_min(IN_W, OUT_W);
  localparam int WR_G = IN_W / GW;
  localparam int RD_G = OUT_W / GW;
  localparam int NGR  = (IN_W * DEPTH) / GW;
  localparam int PW   = (NGR > 1) ? $clog2(NGR) : 1;
  localparam int CW   = $clog2(NGR + 1);

  wcf_flags_t    flags;
  logic [CW-1:0] fill;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          wr_acc, rd_acc;

  assign wr_acc = in_valid && !flags.full;
  assign rd_acc = out_ready && !flags.empty;

  wcf_store #(
    .GW(GW), .WR_G(WR_G), .RD_G(RD_G), .NGR(NGR), .PW(PW)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_acc(wr_acc), .wr_data(in_data),
    .rd_acc(rd_acc), .rd_data(out_data),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr)
  );

  wcf_level #(
    .WR_G(WR_G), .RD_G(RD_G), .NGR(NGR), .DEPTH(DEPTH), .THR_W(THR_W), .CW(CW)
  ) u_level (
    .clk(clk), .rst_n(rst_n),
    .wr_acc(wr_acc), .rd_acc(rd_acc),
    .ae_level(ae_level), .af_level(af_level),
    .fill_o(fill), .flags_o(flags)
  );

  wcf_events u_events (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .out_ready(out_ready),
    .full(flags.full), .empty(flags.empty),
    .ovf_o(overflow), .unf_o(underflow)
  );

  assign in_ready     = !flags.full;
  assign out_valid    = !flags.empty;
  assign empty        = flags.empty;
  assign full         = flags.full;
  assign almost_empty = flags.aempty;
  assign almost_full  = flags.afull;

  // R8
  ptr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(wr_ptr) - int'(rd_ptr) + NGR) % NGR) == (int'(fill) % NGR));

endmodule

// File: tb/widthconv_fifo_bench.sv
`timescale 1ns/1ps
module widthconv_fifo_bench;

  localparam int IN_W  = 32;
  localparam int OUT_W = 8;
  localparam int DEPTH = 8;
  localparam int THR_W = 4;
  localparam int CAP   = IN_W * DEPTH;
  localparam int SL    = IN_W / OUT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [THR_W-1:0] ae_level = 4'd2, af_level = 4'd1;
  logic in_ready, out_valid, empty, full, almost_empty, almost_full, overflow, underflow;
  logic [OUT_W-1:0] out_data;

  int n_chk = 0, n_bad = 0, both_cnt = 0;
  bit done = 1'b0;

  logic [OUT_W-1:0] sb[$];
  int  m_fill = 0;
  bit  e_em = 1, e_fu = 0, e_ae = 1, e_af = 0, e_ov = 0, e_un = 0;

  always #2.5 clk = ~clk;

  widthconv_fifo #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH), .THR_W(THR_W)) u_widthconv_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ae_level(ae_level), .af_level(af_level),
    .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard: sampled at the falling edge, inputs are stable.
  always @(negedge clk) begin
    if (!rst_n) begin
      m_fill = 0; e_em = 1; e_fu = 0; e_ae = 1; e_af = 0; e_ov = 0; e_un = 0;
      sb.delete();
      chk(empty == 1'b1, "R1 empty in reset", 32'(empty), 1);
      chk(almost_empty == 1'b1, "R1 almost_empty in reset", 32'(almost_empty), 1);
      chk(almost_full == 1'b0 && full == 1'b0, "R1 full/almost_full in reset",
          {30'd0, full, almost_full}, 0);
      chk(!out_valid && !overflow && !underflow, "R1 pulses/valid in reset",
          {29'd0, out_valid, overflow, underflow}, 0);
    end else begin
      bit wacc, racc;
      chk(empty == e_em && out_valid == !e_em, "R2 empty/out_valid", {30'd0, empty, out_valid}, {30'd0, e_em, !e_em});
      chk(full == e_fu && in_ready == !e_fu, "R3 full/in_ready", {30'd0, full, in_ready}, {30'd0, e_fu, !e_fu});
      chk(almost_empty == e_ae, "R4 almost_empty", 32'(almost_empty), 32'(e_ae));
      chk(almost_full == e_af, "R5 almost_full", 32'(almost_full), 32'(e_af));
      chk(overflow == e_ov, "R6 overflow pulse", 32'(overflow), 32'(e_ov));
      chk(underflow == e_un, "R7 underflow pulse", 32'(underflow), 32'(e_un));
      chk(!(full && empty), "R10 full with empty", {30'd0, full, empty}, 0);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) chk(1'b0, "R8 unexpected read word", 32'(out_data), 0);
        else begin
          logic [OUT_W-1:0] exp_b;
          exp_b = sb.pop_front();
          chk(out_data == exp_b, "R8 data order", 32'(out_data), 32'(exp_b));
        end
      end
      wacc = in_valid && !e_fu;
      racc = out_ready && !e_em;
      if (wacc && racc) both_cnt++;
      if (wacc) for (int k = 0; k < SL; k++) sb.push_back(in_data[k*OUT_W +: OUT_W]);
      e_ov = in_valid && e_fu;
      e_un = out_ready && e_em;
      // R9: accepted write and read together move the count by IN_W-OUT_W
      m_fill = m_fill + (wacc ? IN_W : 0) - (racc ? OUT_W : 0);
      e_em = m_fill < OUT_W;
      e_fu = (m_fill + IN_W) > CAP;
      e_ae = m_fill <= OUT_W * int'(ae_level);
      e_af = (int'(af_level) >= DEPTH) || (m_fill >= IN_W * (DEPTH - int'(af_level)));
    end
  end

  task automatic cyc(input bit iv, input logic [IN_W-1:0] d, input bit rr);
    @(posedge clk); #1;
    in_valid = iv; in_data = d; out_ready = rr;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8: two words, then slice-by-slice read (LSB slice first)
    cyc(1, 32'h44332211, 0);
    cyc(1, 32'h88776655, 0);
    cyc(0, '0, 0);
    repeat (10) cyc(0, '0, 1);            // R7: last pulls hit empty
    // R6: hold writes past full
    af_level = 4'd2; ae_level = 4'd3;
    for (int i = 0; i < 12; i++) cyc(1, $urandom, 0);
    repeat (40) cyc(0, '0, 1);
    // R9: streaming with both sides on, levels moving
    for (int i = 0; i < 80; i++) begin
      if (i % 7 == 0) begin ae_level = 4'($urandom); af_level = 4'($urandom_range(0, 9)); end
      cyc(1, $urandom, 1);
    end
    // random mix, including margins at or past the depth (R5)
    for (int i = 0; i < 700; i++) begin
      if (i % 11 == 0) begin ae_level = 4'($urandom); af_level = 4'($urandom); end
      cyc($urandom_range(0, 2) != 0, $urandom, $urandom_range(0, 3) != 0);
    end
    // R1: reset during operation
    for (int i = 0; i < 5; i++) cyc(1, $urandom, 0);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1; in_valid = 0; out_ready = 1;
    repeat (4) cyc(0, '0, 1);
    for (int i = 0; i < 6; i++) cyc(1, $urandom, 1);
    repeat (60) cyc(0, '0, 1);
    @(negedge clk); #1;
    chk(sb.size() == 0, "R8 all data delivered", 32'(sb.size()), 0);
    chk(both_cnt > 0, "R9 concurrent transfers seen", 32'(both_cnt), 1);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule